// File: doc/BRIEF.md
# Flash Write Pulse Sequencer

This block times a single programming pulse for a flash array. On a start request it switches on the watchdog enable line, raises the program-setup strobe, waits, raises the program strobe for a chosen pulse width, then lowers program, waits, lowers setup, waits, turns the watchdog enable off, and reports completion with a one-cycle done pulse. Each wait and each of the three pulse widths (short, long and extra) is a cycle count taken from an input register. A zero count means one cycle, and a count of N means N+1 cycles.

The block does not choose the pulse width. The caller picks it with a select input when it issues start. The block does not handle the cell array, the data latches or the verify readback. If the external watchdog expires while a sequence is running, the block drops both strobes, stops the sequence and raises a sticky error flag.

Top module: `flash_pulse_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, watchdog enable, setup, program and error are all low until a start is accepted.
- R2: A start that is accepted in idle makes busy and watchdog enable high in the next cycle, with both strobes still low for exactly that one cycle.
- R3: The setup strobe then stays high for wait_setup+1 cycles before the program strobe rises.
- R4: The program strobe is high for width+1 cycles. The width comes from width_sel as sampled at the accepted start: 2'b00 selects width_short, 2'b01 selects width_long, and 2'b10 or 2'b11 selects width_extra. A change to width_sel during a sequence has no effect on it.
- R5: After the program strobe falls, setup stays high for wait_hold+1 cycles and then falls.
- R6: After setup falls, watchdog enable stays high for wait_release+1 cycles. A single cycle follows with done high, busy still high and watchdog enable low, and then the block is idle.
- R7: The program strobe is never high while setup is low.
- R8: A start while busy is high, including during the done cycle, is ignored and does not change the sequence.
- R9: If wdog_expire is high at a clock edge while busy is high, then in the next cycle setup, program, watchdog enable, busy and done are low and error is high, with no done pulse. The error stays set until the next accepted start clears it. Expiry while idle has no effect.
- R10: A zero in any wait or width register gives an interval of exactly one cycle.
- R11: Each wait or width value is sampled when its interval begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| width_sel_i | input | 2 | Pulse width select |
| wait_setup_i | input | CNT_W | Cycles-1 from setup rise to program rise |
| width_short_i | input | CNT_W | Short pulse width, cycles-1 |
| width_long_i | input | CNT_W | Long pulse width, cycles-1 |
| width_extra_i | input | CNT_W | Extra-programming pulse width, cycles-1 |
| wait_hold_i | input | CNT_W | Cycles-1 from program fall to setup fall |
| wait_release_i | input | CNT_W | Cycles-1 from setup fall to watchdog off |
| wdog_expire_i | input | 1 | Watchdog timeout indication |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wdog_en_o | output | 1 | Watchdog enable/kick, held for the sequence |
| setup_o | output | 1 | Program-setup strobe |
| prog_o | output | 1 | Program strobe |
| err_o | output | 1 | Sticky watchdog-abort flag |

## Verification
The bench compares every cycle against a queue of expected output vectors that it builds when a start is accepted. This catches any interval that is off by one, including all-zero loads, where a counter that ignored the "zero means one cycle" rule would either skip a phase or hang. Some stimuli change width_sel in the middle of a pulse or hold start high through the done cycle. A design that did not latch the select would produce a pulse of the wrong length, and one that accepted a start while busy would restart or stretch the sequence. A watchdog expiry is injected during the program pulse, and another while idle. These expose a strobe left high after an abort, a spurious done pulse, an error flag that is not sticky, and an error flag that is not cleared by the next start.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SETUP,
    ST_PROG,
    ST_HOLD,
    ST_REL,
    ST_DONE
  } fps_state_e;

  localparam logic [1:0] SEL_SHORT = 2'b00;
  localparam logic [1:0] SEL_LONG  = 2'b01;
endpackage

// File: rtl/fps_down_counter.sv
module fps_down_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // no wrap below zero (R10)
  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/fps_width_mux.sv
module fps_width_mux
  import fps_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] short_i,
  input  logic [W-1:0] long_i,
  input  logic [W-1:0] extra_i,
  output logic [W-1:0] width_o
);
  always_comb begin
    case (sel_i)
      SEL_SHORT: width_o = short_i;
      SEL_LONG:  width_o = long_i;
      default:   width_o = extra_i;
    endcase
  end
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   sel_i,
  input  logic         expire_i,
  input  logic [W-1:0] t_setup_i,
  input  logic [W-1:0] width_i,
  input  logic [W-1:0] t_hold_i,
  input  logic [W-1:0] t_rel_i,
  input  logic         cnt_zero_i,
  output logic [1:0]   sel_q_o,
  output logic         cnt_load_o,
  output logic [W-1:0] cnt_val_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         wdog_en_o,
  output logic         setup_o,
  output logic         prog_o,
  output logic         err_o
);
  fps_state_e state_q, state_d;
  logic       accept;
  logic       abort;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign abort  = (state_q != ST_IDLE) && expire_i;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ARM;
      ST_ARM: begin
        state_d    = ST_SETUP;
        cnt_load_o = 1'b1;
        cnt_val_o  = t_setup_i;
      end
      ST_SETUP: if (cnt_zero_i) begin
        state_d    = ST_PROG;
        cnt_load_o = 1'b1;
        cnt_val_o  = width_i;
      end
      ST_PROG:  if (cnt_zero_i) begin
        state_d    = ST_HOLD;
        cnt_load_o = 1'b1;
        cnt_val_o  = t_hold_i;
      end
      ST_HOLD:  if (cnt_zero_i) begin
        state_d    = ST_REL;
        cnt_load_o = 1'b1;
        cnt_val_o  = t_rel_i;
      end
      ST_REL:   if (cnt_zero_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (abort) begin
      state_d    = ST_IDLE;
      cnt_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q_o <= '0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) sel_q_o <= sel_i;
      if (abort)       err_o <= 1'b1;
      else if (accept) err_o <= 1'b0;
    end
  end

  // Moore decode: strobes change only on state edges
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign wdog_en_o = busy_o && !done_o;
  assign setup_o   = (state_q == ST_SETUP) || (state_q == ST_PROG) || (state_q == ST_HOLD);
  assign prog_o    = (state_q == ST_PROG);

  assert_prog_needs_setup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> setup_o);
  assert_prog_rise_after_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(setup_o));
  assert_setup_under_wdog_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(setup_o) |-> wdog_en_o);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !expire_i) |=> busy_o);
  assert_expire_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && expire_i) |=> (!setup_o && !prog_o && !busy_o && err_o));
endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       width_sel_i,
  input  logic [CNT_W-1:0] wait_setup_i,
  input  logic [CNT_W-1:0] width_short_i,
  input  logic [CNT_W-1:0] width_long_i,
  input  logic [CNT_W-1:0] width_extra_i,
  input  logic [CNT_W-1:0] wait_hold_i,
  input  logic [CNT_W-1:0] wait_release_i,
  input  logic             wdog_expire_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             wdog_en_o,
  output logic             setup_o,
  output logic             prog_o,
  output logic             err_o
);
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] width_sel;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_load;
  logic             cnt_zero;

  fps_width_mux #(.W(CNT_W)) u_mux (
    .sel_i   (sel_q),
    .short_i (width_short_i),
    .long_i  (width_long_i),
    .extra_i (width_extra_i),
    .width_o (width_sel)
  );

  fps_down_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  fps_ctrl #(.W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sel_i      (width_sel_i),
    .expire_i   (wdog_expire_i),
    .t_setup_i  (wait_setup_i),
    .width_i    (width_sel),
    .t_hold_i   (wait_hold_i),
    .t_rel_i    (wait_release_i),
    .cnt_zero_i (cnt_zero),
    .sel_q_o    (sel_q),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wdog_en_o  (wdog_en_o),
    .setup_o    (setup_o),
    .prog_o     (prog_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/flash_pulse_seq_tb_top.sv
`timescale 1ns/1ps
module flash_pulse_seq_tb_top;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_r = 1'b0;
  logic [1:0]   sel_r = 2'b00;
  logic [W-1:0] ts_r = '0, sh_r = '0, lg_r = '0, ex_r = '0, th_r = '0, tr_r = '0;
  logic         exp_r = 1'b0;
  logic         busy_o, done_o, wdog_en_o, setup_o, prog_o, err_o;

  int    vectors = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  // expected vector layout {done, busy, wdog_en, setup, prog}
  logic [4:0] q[$];
  logic [4:0] cur_m = '0;
  logic       err_m = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_pulse_seq #(.CNT_W(W)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_r), .width_sel_i (sel_r),
    .wait_setup_i (ts_r), .width_short_i (sh_r), .width_long_i (lg_r),
    .width_extra_i (ex_r), .wait_hold_i (th_r), .wait_release_i (tr_r),
    .wdog_expire_i (exp_r), .busy_o (busy_o), .done_o (done_o),
    .wdog_en_o (wdog_en_o), .setup_o (setup_o), .prog_o (prog_o), .err_o (err_o)
  );

  task automatic push_n(input logic [4:0] v, input int n);
    for (int i = 0; i < n; i++) q.push_back(v);
  endtask

  task automatic model_step();
    int w;
    if (cur_m[3] && exp_r) begin
      q.delete();
      cur_m = '0;
      err_m = 1'b1;
    end else begin
      if (!cur_m[3] && start_r) begin
        err_m = 1'b0;
        w = (sel_r == 2'b00) ? int'(sh_r) : (sel_r == 2'b01) ? int'(lg_r) : int'(ex_r);
        push_n(5'b01100, 1);
        push_n(5'b01110, int'(ts_r) + 1);
        push_n(5'b01111, w + 1);
        push_n(5'b01110, int'(th_r) + 1);
        push_n(5'b01100, int'(tr_r) + 1);
        push_n(5'b11000, 1);
      end
      if (q.size() != 0) cur_m = q.pop_front();
      else cur_m = '0;
    end
  endtask

  task automatic compare();
    logic [5:0] got, exp;
    got = {done_o, busy_o, wdog_en_o, setup_o, prog_o, err_o};
    exp = {cur_m, err_m};
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {done,busy,wdog,setup,prog,err} got %b exp %b at %0t", cur_tag, got, exp, $time);
    end
    vectors++;
    if (prog_o && !setup_o) begin
      fails++;
      $display("FAIL R7: prog without setup got prog=%b setup=%b exp setup=1", prog_o, setup_o);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic run_seq(input string tag, input int extra);
    cur_tag = tag;
    start_r = 1'b1;
    tick();
    start_r = 1'b0;
    while (q.size() != 0) tick();
    repeat (extra) tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run hung, got no finish exp finish");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    cur_tag = "R1";
    compare();
    rst_ni = 1'b1;
    repeat (3) tick();

    // R2 R3 R4 R5 R6: short width
    ts_r = 3; sh_r = 5; lg_r = 9; ex_r = 2; th_r = 2; tr_r = 4;
    sel_r = 2'b00;
    run_seq("R3_R4_R5_R6 short", 2);
    // R4: long width
    sel_r = 2'b01;
    run_seq("R4 long", 1);
    // R4: extra width via both codes
    sel_r = 2'b10;
    run_seq("R4 extra 10", 1);
    sel_r = 2'b11;
    run_seq("R4 extra 11", 1);

    // R4: select change mid-sequence has no effect
    cur_tag = "R4 sel latched";
    sel_r = 2'b00; sh_r = 3; lg_r = 8;
    start_r = 1'b1; tick(); start_r = 1'b0;
    tick(); sel_r = 2'b01;
    repeat (4) tick(); sel_r = 2'b10;
    while (q.size() != 0) tick();
    tick();

    // R10: all zero loads give single-cycle intervals
    ts_r = 0; sh_r = 0; th_r = 0; tr_r = 0; sel_r = 2'b00;
    run_seq("R10 zero loads", 2);

    // R8: start held high through sequence and done cycle
    ts_r = 1; sh_r = 2; th_r = 1; tr_r = 1;
    cur_tag = "R8 start while busy";
    start_r = 1'b1;
    repeat (14) tick();
    start_r = 1'b0;
    while (q.size() != 0) tick();
    tick();

    // R9: expiry in the program pulse
    ts_r = 2; sh_r = 6; th_r = 2; tr_r = 2; sel_r = 2'b00;
    cur_tag = "R9 abort";
    start_r = 1'b1; tick(); start_r = 1'b0;
    repeat (5) tick();
    exp_r = 1'b1; tick(); exp_r = 1'b0;
    repeat (3) tick();
    // R9: expiry while idle has no effect, error stays
    cur_tag = "R9 idle expire";
    exp_r = 1'b1; repeat (2) tick(); exp_r = 1'b0;
    tick();
    // R9: next start clears error; R11 new values sampled
    th_r = 5;
    run_seq("R9_R11 restart clears err", 2);

    // R9: expiry during done cycle still aborts
    cur_tag = "R9 expire at done";
    ts_r = 0; sh_r = 0; th_r = 0; tr_r = 0;
    start_r = 1'b1; tick(); start_r = 1'b0;
    while (q.size() > 1) tick();
    tick();
    exp_r = 1'b1; tick(); exp_r = 1'b0;
    repeat (2) tick();

    finish_run();
  end
endmodule